// File: doc/BRIEF.md
# ADC Serial Port Slave

This block is the converter-side serial port of a 12-bit, 8-channel sampling ADC. The host lowers the chip select, clocks the serial line sixteen times and, on the first eight rising edges, sends a control byte. On the same sixteen clocks it reads back one conversion result with four leading zeros. The block works out where each edge falls in the frame. It captures the control byte and tells the analog side when to stop tracking and start converting. When automatic power-down is selected, it also asks the analog side to wake up.

The sampled inputs `cs_n`, `sclk` and `din` are assumed to be synchronous to the block clock `clk`, which runs several times faster than the serial clock. The block finds serial clock edges by comparing the current serial clock level with the level registered on the previous `clk` cycle. The channel written in a frame is used for the conversion of the next frame. The selection changes only when a full sixteen-clock frame completes. A behavioural converter stub supplies the 12-bit result on `conv_result`, and the block latches it when the conversion starts.

Top module: `adc_serial_port`

## Requirements
- R1: `dout_oe` is 1 while `cs_n` is low and 0 while it is high. `dout_oe`=0 stands for a high-impedance data output.
- R2: `conv_start` is a one-`clk` pulse issued one `clk` after the second serial clock rising edge of a frame. From that edge, `track` is 0 (hold) until the frame completes or `cs_n` rises. Otherwise `track` is 1.
- R3: A frame is sixteen rising edges. If `cs_n` stays low, the next edge starts a new frame with its own control write, leading zeros and conversion.
- R4: On the eighth rising edge of a frame, `ctrl_reg` loads the first eight `din` bits, the first bit received landing in bit 7. A frame that ends with fewer than eight rising edges leaves `ctrl_reg` unchanged.
- R5: Control byte layout: bit 7 is ignored, bit 6 is zero, bits 5:3 are the channel, bit 2 is the reference select and bits 1:0 are the power mode. Power mode 2'b10 means automatic power-down.
- R6: `conv_chan` gives the channel of the control byte from the most recent completed frame. The conversion started in a frame therefore uses the channel written in the frame before it.
- R7: `dout` sends 0,0,0,0, then result bits 11 down to 0. It changes only on serial clock falling edges, and bit k (counting from 0) is valid at rising edge k+1.
- R8: `dout` is 0 as soon as `cs_n` falls, whether the serial clock idles high or low.
- R9: A one-`clk` pulse on `wake_req` follows the first serial clock falling edge after `cs_n` falls, if the stored power mode is automatic power-down. There is at most one pulse per low period of `cs_n`.
- R10: A frame aborted by `cs_n` rising before sixteen rising edges leaves `conv_chan` unchanged.
- R11: After reset: `ctrl_reg`=0, `conv_chan`=0, `dout`=0, `track`=1, `conv_start`=0 and `wake_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock, faster than the serial clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cs_n | input | 1 | active-low chip select, frames a transfer |
| sclk | input | 1 | serial clock from the host |
| din | input | 1 | serial control data from the host |
| conv_result | input | 12 | parallel result from the converter |
| dout | output | 1 | serial result data |
| dout_oe | output | 1 | output enable for `dout`, 0 means high impedance |
| track | output | 1 | 1 = track, 0 = hold |
| conv_start | output | 1 | conversion start pulse |
| wake_req | output | 1 | wake-up request pulse |
| conv_chan | output | 3 | channel used for the conversion |
| ctrl_reg | output | 8 | stored control byte |

## Verification
Six table frames pair different control bytes with different results: all ones, a lone MSB, alternating bits and a single LSB. Together they expose bit reversal, a shift off by one and a missing leading zero. Each table row also carries the channel from the previous row, so a design that converts the current frame's channel shows up at once. Frames with an idle-high and an idle-low serial clock alternate, which separates a first zero driven at chip select from one driven only by the first falling edge. Directed frames end after two, five and ten clocks to cover the hold window and the abort rules. One thirty-two clock frame with chip select held low covers the back-to-back restart and the one-wake-per-select rule.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL   = 2'b00,
    PM_FULLDOWN = 2'b01,
    PM_AUTO     = 2'b10,
    PM_STANDBY  = 2'b11
  } pmode_e;

  localparam int CTRL_W   = 8;
  localparam int CHAN_LSB = 3;
  localparam int CHAN_W   = 3;

  function automatic logic [CHAN_W-1:0] ctrl_chan(input logic [CTRL_W-1:0] c);
    return c[CHAN_LSB +: CHAN_W];
  endfunction

  function automatic pmode_e ctrl_pmode(input logic [CTRL_W-1:0] c);
    return pmode_e'(c[1:0]);
  endfunction
endpackage

// File: rtl/sclk_edge_det.sv
module sclk_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq #(
  parameter int FRAME      = 16,
  parameter int SAMPLE_IDX = 1,
  localparam int CNT_W     = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rise,
  input  logic             fall,
  output logic [CNT_W-1:0] cnt,
  output logic             xfer_done,
  output logic             sample_edge,
  output logic             first_fall
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] SIDX = CNT_W'(SAMPLE_IDX);
  logic fall_seen;

  always_ff @(posedge clk or negedge rst_n or posedge cs_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cs_n)   cnt <= '0;
    else if (rise)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n or posedge cs_n) begin
    if (!rst_n)      fall_seen <= 1'b0;
    else if (cs_n)   fall_seen <= 1'b0;
    else if (fall)   fall_seen <= 1'b1;
  end

  assign xfer_done   = !cs_n && rise && (cnt == LAST);
  assign sample_edge = !cs_n && rise && (cnt == SIDX);
  assign first_fall  = !cs_n && fall && !fall_seen;
endmodule

// File: rtl/ctrl_capture.sv
module ctrl_capture #(
  parameter int CW    = 8,
  parameter int CHW   = 3,
  parameter int CH_LSB = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rise,
  input  logic             din,
  input  logic [CNT_W-1:0] cnt,
  input  logic             xfer_done,
  output logic             ctrl_load,
  output logic [CW-1:0]    ctrl_reg,
  output logic [CHW-1:0]   active_chan
);
  localparam logic [CNT_W-1:0] LOAD_IDX = CNT_W'(CW - 1);
  logic [CW-2:0] ctrl_sh;
  logic          shift_en;

  assign shift_en  = !cs_n && rise && (cnt < LOAD_IDX);
  assign ctrl_load = !cs_n && rise && (cnt == LOAD_IDX);

  always_ff @(posedge clk or negedge rst_n or posedge cs_n) begin
    if (!rst_n)        ctrl_sh <= '0;
    else if (cs_n)     ctrl_sh <= '0;
    else if (shift_en) ctrl_sh <= {ctrl_sh[CW-3:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_reg    <= '0;
      active_chan <= '0;
    end else begin
      if (ctrl_load) ctrl_reg    <= {ctrl_sh, din};
      if (xfer_done) active_chan <= ctrl_reg[CH_LSB +: CHW];
    end
  end
endmodule

// File: rtl/result_shifter.sv
module result_shifter #(
  parameter int RW    = 12,
  parameter int FRAME = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             fall,
  input  logic             sample_edge,
  input  logic [CNT_W-1:0] cnt,
  input  logic [RW-1:0]    conv_result,
  output logic             dout
);
  localparam int LEAD = FRAME - RW;
  logic [RW-1:0] res_q;

  function automatic logic frame_bit(input logic [CNT_W-1:0] pos, input logic [RW-1:0] r);
    int p;
    p = int'(pos);
    if (p < LEAD) return 1'b0;
    return r[RW-1-(p-LEAD)];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           res_q <= '0;
    else if (sample_edge) res_q <= conv_result;
  end

  always_ff @(posedge clk or negedge rst_n or posedge cs_n) begin
    if (!rst_n)      dout <= 1'b0;
    else if (cs_n)   dout <= 1'b0;
    else if (fall)   dout <= frame_bit(cnt, res_q);
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter int FRAME      = 16,
  parameter int SAMPLE_IDX = 1,
  localparam int CNT_W     = $clog2(FRAME)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [RES_W-1:0]  conv_result,
  output logic              dout,
  output logic              dout_oe,
  output logic              track,
  output logic              conv_start,
  output logic              wake_req,
  output logic [CHAN_W-1:0] conv_chan,
  output logic [CTRL_W-1:0] ctrl_reg
);
  logic             sclk_rise, sclk_fall;
  logic [CNT_W-1:0] cnt;
  logic             xfer_done, sample_edge, first_fall, ctrl_load;

  sclk_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .rise(sclk_rise), .fall(sclk_fall)
  );

  xfer_seq #(.FRAME(FRAME), .SAMPLE_IDX(SAMPLE_IDX)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise(sclk_rise), .fall(sclk_fall),
    .cnt(cnt), .xfer_done(xfer_done), .sample_edge(sample_edge), .first_fall(first_fall)
  );

  ctrl_capture #(.CW(CTRL_W), .CHW(CHAN_W), .CH_LSB(CHAN_LSB), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise(sclk_rise), .din(din), .cnt(cnt),
    .xfer_done(xfer_done), .ctrl_load(ctrl_load), .ctrl_reg(ctrl_reg), .active_chan(conv_chan)
  );

  result_shifter #(.RW(RES_W), .FRAME(FRAME), .CNT_W(CNT_W)) u_res (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fall(sclk_fall), .sample_edge(sample_edge),
    .cnt(cnt), .conv_result(conv_result), .dout(dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      wake_req   <= 1'b0;
    end else begin
      conv_start <= sample_edge;
      wake_req   <= first_fall && (ctrl_pmode(ctrl_reg) == PM_AUTO);
    end
  end

  assign dout_oe = !cs_n;
  assign track   = cs_n || (cnt <= CNT_W'(SAMPLE_IDX));
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int CW  = 8,
  parameter int CHW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_n,
  input logic           sclk_fall,
  input logic           xfer_done,
  input logic           ctrl_load,
  input logic           conv_start,
  input logic           wake_req,
  input logic           track,
  input logic           dout,
  input logic [CHW-1:0] conv_chan,
  input logic [CW-1:0]  ctrl_reg
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R2
  AST_START_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !cs_n) |-> !track); // R2
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req); // R9
  AST_CHAN_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(xfer_done) |-> $stable(conv_chan)); // R10
  AST_CTRL_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_load) |-> $stable(ctrl_reg)); // R4
  AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$past(sclk_fall)) |-> $stable(dout)); // R7
endmodule

bind adc_serial_port adc_serial_port_chk #(.CW(adc_sp_pkg::CTRL_W), .CHW(adc_sp_pkg::CHAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_fall(sclk_fall), .xfer_done(xfer_done),
  .ctrl_load(ctrl_load), .conv_start(conv_start), .wake_req(wake_req), .track(track),
  .dout(dout), .conv_chan(conv_chan), .ctrl_reg(ctrl_reg)
);

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic [11:0] conv_result = '0;
  logic        dout, dout_oe, track, conv_start, wake_req;
  logic [2:0]  conv_chan;
  logic [7:0]  ctrl_reg;

  int errors = 0;
  int checks = 0;
  int n_start = 0;
  int n_wake = 0;
  logic [2:0] last_conv_chan = '0;

  always #10 clk = ~clk;

  adc_serial_port i_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .conv_result(conv_result), .dout(dout), .dout_oe(dout_oe), .track(track),
    .conv_start(conv_start), .wake_req(wake_req), .conv_chan(conv_chan), .ctrl_reg(ctrl_reg)
  );

  always @(negedge clk) begin
    if (conv_start) begin
      n_start++;
      last_conv_chan = conv_chan;
    end
    if (wake_req) n_wake++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] c, input logic [11:0] r, input int n,
                      input bit idle_hi, input bit keep, output logic [31:0] got);
    got = '0;
    conv_result = r;
    @(negedge clk) sclk = idle_hi;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 dout zero at select", {31'b0, dout}, 32'h0);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      din = ((i % 16) < 8) ? c[7 - (i % 16)] : 1'b0;
      repeat (4) @(negedge clk);
      got = {got[30:0], dout};
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    if (!keep) cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // {ctrl byte, result}
  localparam logic [19:0] VEC [6] = '{
    {8'h2A, 12'hABC}, {8'h1C, 12'h001}, {8'hB8, 12'hFFF},
    {8'h02, 12'h800}, {8'h35, 12'h555}, {8'h12, 12'h7FE}
  };

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic [7:0]  prev_ctrl;
    logic [2:0]  exp_chan;
    int s0, w0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 ctrl_reg", {24'b0, ctrl_reg}, 32'h0);
    chk("R11 conv_chan", {29'b0, conv_chan}, 32'h0);
    chk("R11 track/oe/dout/pulses", {27'b0, track, dout_oe, dout, conv_start, wake_req}, 32'h10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    prev_ctrl = 8'h00;
    exp_chan = 3'd0;

    for (int v = 0; v < 6; v++) begin
      logic [7:0]  c;
      logic [11:0] r;
      c = VEC[v][19:12];
      r = VEC[v][11:0];
      s0 = n_start; w0 = n_wake;
      xfer(c, r, 16, (v % 2) == 0, 1'b0, got);
      chk("R7 frame bits", {16'b0, got[15:0]}, {16'b0, 4'b0, r});
      chk("R4 ctrl_reg", {24'b0, ctrl_reg}, {24'b0, c});
      chk("R6 conv uses previous channel", {29'b0, last_conv_chan}, {29'b0, exp_chan});
      chk("R5 channel field", {29'b0, conv_chan}, {29'b0, c[5:3]});
      chk("R3 one conversion per frame", n_start - s0, 1);
      chk("R9 wake per power mode", n_wake - w0, (prev_ctrl[1:0] == 2'b10) ? 1 : 0);
      chk("R1 oe off after select", {31'b0, dout_oe}, 32'h0);
      prev_ctrl = c;
      exp_chan = c[5:3];
    end

    // R2 hold after the second rising edge, track again after select rises
    w0 = n_wake;
    xfer(8'h12, 12'h123, 2, 1'b1, 1'b1, got);
    chk("R2 hold after second rise", {31'b0, track}, 32'h0);
    chk("R1 oe on while selected", {31'b0, dout_oe}, 32'h1);
    @(negedge clk) cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 track after select rises", {31'b0, track}, 32'h1);
    chk("R1 oe off", {31'b0, dout_oe}, 32'h0);
    chk("R9 wake in auto mode", n_wake - w0, 1);
    chk("R10 two-clock abort keeps channel", {29'b0, conv_chan}, {29'b0, exp_chan});

    // R10 abort after ten clocks: control written, channel kept
    xfer(8'h3A, 12'h456, 10, 1'b0, 1'b0, got);
    chk("R4 ctrl_reg after ten clocks", {24'b0, ctrl_reg}, 32'h3A);
    chk("R10 channel kept on abort", {29'b0, conv_chan}, {29'b0, exp_chan});

    // R4 abort after five clocks: control untouched
    xfer(8'h08, 12'h456, 5, 1'b1, 1'b0, got);
    chk("R4 short frame keeps ctrl_reg", {24'b0, ctrl_reg}, 32'h3A);

    // R3 back-to-back frames with select held low
    s0 = n_start; w0 = n_wake;
    xfer(8'h20, 12'h9A5, 32, 1'b1, 1'b0, got);
    chk("R3 two frames of bits", got, {4'b0, 12'h9A5, 4'b0, 12'h9A5});
    chk("R3 two conversions", n_start - s0, 2);
    chk("R6 second frame uses first frame channel", {29'b0, last_conv_chan}, 32'h4);
    chk("R9 single wake per select", n_wake - w0, 1);
    chk("R6 conv_chan after frames", {29'b0, conv_chan}, 32'h4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule